// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the controller of a single-product vending machine that sells one item for 20 cents. Each coin arrives as a one-cycle `coin_valid` strobe with a two-bit code. The controller keeps the credit paid so far in 5-cent units, from 0 to 15 cents, in a two-bit register. When a coin brings the total to 20 cents or more, it raises `dispense` and drives the change outputs in the same cycle.

At most one dime and one nickel of change can be paid per coin event, so at most 15 cents per event. The case where this matters is a quarter inserted at 15 cents. That gives 40 cents, and 20 cents of it is excess. The controller pays back 15 cents and keeps 5 cents as credit toward the next item.

The outputs are computed from the current credit and the incoming coin. They are high only in the strobe cycle. The credit register changes only on accepted coin events.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset sets the credit to 0 cents. After reset, one dime gives no output and a second dime dispenses with no change.
- R2: While `coin_valid` is low, the credit holds and all three outputs stay low, whatever `coin_code` carries.
- R3: Coin code 2'b11 is not a coin. With `coin_valid` high it gives no output and leaves the credit unchanged.
- R4: Coin codes are 2'b00 = nickel (5 cents), 2'b01 = dime (10 cents) and 2'b10 = quarter (25 cents). A coin that leaves the total below 20 cents adds its value to the credit and gives no output.
- R5: A coin that makes the total exactly 20 cents dispenses with no change, and the credit returns to 0.
- R6: A quarter at 0 cents dispenses, returns a nickel, and leaves the credit at 0.
- R7: A quarter at 5 cents dispenses, returns a dime, and leaves the credit at 0.
- R8: A quarter at 10 cents dispenses, returns both a dime and a nickel, and leaves the credit at 0.
- R9: A quarter at 15 cents dispenses, returns a dime and a nickel, and carries 5 cents of credit forward.
- R10: A dime at 15 cents dispenses, returns a nickel, and leaves the credit at 0.
- R11: A change output is high only together with `dispense`, and any output is high only in a cycle where `coin_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_valid | input | 1 | One-cycle strobe marking a coin event |
| coin_code | input | 2 | Coin type: 00 nickel, 01 dime, 10 quarter, 11 unused |
| dispense | output | 1 | Release the item, high in the strobe cycle |
| ret_nickel | output | 1 | Pay back one nickel, high in the strobe cycle |
| ret_dime | output | 1 | Pay back one dime, high in the strobe cycle |

## Verification
The bench builds the controller with its default parameters: a 20-cent price, which gives a two-bit credit register, and coin values that fit in three bits. With these values all sixteen combinations of credit and coin code can be reached, including the quarter at 15 cents that carries a remainder forward. The random stream mixes idle cycles and unused codes with real coins, so credit builds through every state and wraps through a sale many times. Directed sequences force each quarter case, the exact-price sale and a reset in the middle of a transaction.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [1:0] {
        COIN_NICKEL  = 2'b00,
        COIN_DIME    = 2'b01,
        COIN_QUARTER = 2'b10,
        COIN_NONE    = 2'b11
    } coin_e;

    // Worth of each coin, counted in 5-cent units
    localparam int unsigned NICKEL_UNITS  = 1;
    localparam int unsigned DIME_UNITS    = 2;
    localparam int unsigned QUARTER_UNITS = 5;

    // Most change that can be paid per event: one dime plus one nickel
    localparam int unsigned CHANGE_CAP_UNITS = DIME_UNITS + NICKEL_UNITS;

    typedef struct packed {
        logic dispense;
        logic ret_nickel;
        logic ret_dime;
    } vend_out_t;

endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value
    import vend_pkg::*;
#(
    parameter int unsigned VAL_W = 3
) (
    input  coin_e              code,
    output logic [VAL_W-1:0]   units,
    output logic               legal
);

    always_comb begin
        units = '0;
        legal = 1'b1;
        unique case (code)
            COIN_NICKEL:  units = VAL_W'(NICKEL_UNITS);
            COIN_DIME:    units = VAL_W'(DIME_UNITS);
            COIN_QUARTER: units = VAL_W'(QUARTER_UNITS);
            default:      legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/vend_settle.sv
module vend_settle
    import vend_pkg::*;
#(
    parameter int unsigned PRICE_UNITS = 4,
    parameter int unsigned CREDIT_W    = 2,
    parameter int unsigned VAL_W       = 3,
    parameter int unsigned SUM_W       = 4
) (
    input  logic [CREDIT_W-1:0] credit,
    input  logic [VAL_W-1:0]    units,
    output logic [CREDIT_W-1:0] credit_next,
    output vend_out_t           outs
);

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] excess;
    logic [SUM_W-1:0] give;
    logic [SUM_W-1:0] keep;

    always_comb begin
        total       = SUM_W'(credit) + SUM_W'(units);
        excess      = '0;
        give        = '0;
        keep        = '0;
        outs        = '0;
        credit_next = total[CREDIT_W-1:0];
        if (total >= SUM_W'(PRICE_UNITS)) begin
            excess = total - SUM_W'(PRICE_UNITS);
            give   = (excess > SUM_W'(CHANGE_CAP_UNITS)) ? SUM_W'(CHANGE_CAP_UNITS) : excess;
            keep   = excess - give;
            outs.dispense   = 1'b1;
            outs.ret_nickel = give[0];
            outs.ret_dime   = give[1];
            credit_next     = keep[CREDIT_W-1:0];
        end
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int unsigned PRICE_UNITS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       coin_valid,
    input  logic [1:0] coin_code,
    output logic       dispense,
    output logic       ret_nickel,
    output logic       ret_dime
);

    localparam int unsigned CREDIT_W = $clog2(PRICE_UNITS);
    localparam int unsigned VAL_W    = $clog2(QUARTER_UNITS + 1);
    localparam int unsigned SUM_W    = ((CREDIT_W > VAL_W) ? CREDIT_W : VAL_W) + 1;

    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
    } state_t;

    state_t              st_d, st_q;
    logic [VAL_W-1:0]    coin_units;
    logic                coin_legal;
    logic [CREDIT_W-1:0] settle_credit;
    vend_out_t           settle_outs;
    vend_out_t           outs_d;
    logic [CREDIT_W-1:0] credit_q;

    vend_coin_value #(.VAL_W(VAL_W)) u_value (
        .code  (coin_e'(coin_code)),
        .units (coin_units),
        .legal (coin_legal)
    );

    vend_settle #(
        .PRICE_UNITS (PRICE_UNITS),
        .CREDIT_W    (CREDIT_W),
        .VAL_W       (VAL_W),
        .SUM_W       (SUM_W)
    ) u_settle (
        .credit      (st_q.credit),
        .units       (coin_units),
        .credit_next (settle_credit),
        .outs        (settle_outs)
    );

    always_comb begin
        st_d   = st_q;
        outs_d = '0;
        if (coin_valid && coin_legal) begin
            st_d.credit = settle_credit;
            outs_d      = settle_outs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign credit_q   = st_q.credit;
    assign dispense   = outs_d.dispense;
    assign ret_nickel = outs_d.ret_nickel;
    assign ret_dime   = outs_d.ret_dime;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int unsigned CREDIT_W = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                coin_valid,
    input logic [1:0]          coin_code,
    input logic                dispense,
    input logic                ret_nickel,
    input logic                ret_dime,
    input logic [CREDIT_W-1:0] credit_q
);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !coin_valid |=> $stable(credit_q));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !coin_valid |-> !(dispense || ret_nickel || ret_dime));

    assert_change_with_sale_R11: assert property (@(posedge clk) disable iff (rst)
        (ret_nickel || ret_dime) |-> dispense);

    assert_bad_code_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b11) |=> $stable(credit_q));

    assert_bad_code_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b11) |-> !(dispense || ret_nickel || ret_dime));

    assert_carry_remainder_R9: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b10 && credit_q == CREDIT_W'(3)) |=> credit_q == CREDIT_W'(1));

    assert_full_change_R9: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b10 && credit_q == CREDIT_W'(3)) |-> (dispense && ret_nickel && ret_dime));

endmodule

bind vend_ctrl vend_ctrl_chk #(.CREDIT_W(CREDIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .coin_valid (coin_valid),
    .coin_code  (coin_code),
    .dispense   (dispense),
    .ret_nickel (ret_nickel),
    .ret_dime   (ret_dime),
    .credit_q   (credit_q)
);

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_valid = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       dispense, ret_nickel, ret_dime;

    int checks = 0;
    int errors = 0;
    int model_credit = 0;   // in 5-cent units

    always #(CLK_P/2) clk = ~clk;

    vend_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .coin_valid (coin_valid),
        .coin_code  (coin_code),
        .dispense   (dispense),
        .ret_nickel (ret_nickel),
        .ret_dime   (ret_dime)
    );

    function automatic int coin_units(input logic [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 2;
            2'b10: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(input logic v, input logic [1:0] c, input int cr);
        int tot;
        if (!v) return "R2";
        if (c == 2'b11) return "R3";
        tot = cr + coin_units(c);
        if (tot < 4) return "R4";
        if (tot == 4) return "R5";
        if (c == 2'b10) begin
            case (cr)
                0: return "R6";
                1: return "R7";
                2: return "R8";
                default: return "R9";
            endcase
        end
        return "R10";
    endfunction

    // expected {dispense, ret_nickel, ret_dime}; updates model credit
    function automatic logic [2:0] expect_step(input logic v, input logic [1:0] c);
        int tot, ex, give;
        if (!v || c == 2'b11) return 3'b000;
        tot = model_credit + coin_units(c);
        if (tot < 4) begin
            model_credit = tot;
            return 3'b000;
        end
        ex   = tot - 4;
        give = (ex > 3) ? 3 : ex;
        model_credit = ex - give;
        return {1'b1, give[0], give[1]};
    endfunction

    task automatic step(input logic v, input logic [1:0] c);
        logic [2:0] exp_o;
        logic [2:0] got;
        string t;
        @(negedge clk);
        coin_valid = v;
        coin_code  = c;
        t = tag_for(v, c, model_credit);
        exp_o = expect_step(v, c);
        #1;
        got = {dispense, ret_nickel, ret_dime};
        checks++;
        if (got !== exp_o) begin
            errors++;
            $display("FAIL %s: outputs got %b expected %b (code %b valid %b)", t, got, exp_o, c, v);
        end
        if (got[1:0] != 2'b00 && !got[2]) begin
            checks++;
            errors++;
            $display("FAIL R11: change %b without dispense, expected 0", got[1:0]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        coin_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        checks++;
        if ({dispense, ret_nickel, ret_dime} !== 3'b000) begin
            errors++;
            $display("FAIL R1: outputs in reset got %b expected 000", {dispense, ret_nickel, ret_dime});
        end
        rst = 1'b0;
        model_credit = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        // R1: fresh credit is zero
        step(1'b1, 2'b01);
        step(1'b1, 2'b01);
        // R2: idle with quarter code on the bus
        step(1'b1, 2'b00);
        step(1'b0, 2'b10);
        step(1'b0, 2'b10);
        // R3: unused code ignored, then reach 20 exactly (R5)
        step(1'b1, 2'b11);
        step(1'b1, 2'b01);
        step(1'b1, 2'b00);
        // R6
        step(1'b1, 2'b10);
        // R7
        step(1'b1, 2'b00);
        step(1'b1, 2'b10);
        // R8
        step(1'b1, 2'b01);
        step(1'b1, 2'b10);
        // R9 then R5 from carried nickel
        step(1'b1, 2'b01);
        step(1'b1, 2'b00);
        step(1'b1, 2'b10);
        step(1'b1, 2'b00);
        step(1'b1, 2'b01);
        // R10
        step(1'b1, 2'b01);
        step(1'b1, 2'b00);
        step(1'b1, 2'b01);
        // R1 mid-transaction reset
        step(1'b1, 2'b01);
        step(1'b1, 2'b00);
        do_reset();
        step(1'b1, 2'b01);
        step(1'b1, 2'b00);
        step(1'b1, 2'b00);
        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic v;
            logic [1:0] c;
            v = ($urandom % 4) != 0;
            c = 2'($urandom % 4);
            step(v, c);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule